// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Register Block

This block sits in the host-facing register space of a two-channel disk host adapter. It gathers two interrupt sources for each channel into status bits. One source is the drive's own interrupt line, which is a level input. The other is a bus-master completion event from the DMA engine. The block then applies a per-channel mask and produces one host interrupt line per channel, and each line has its own selectable polarity.

The host reaches the block through a byte-wide I/O port with a 2-bit byte offset. The status offset behaves differently for reads and writes. A read returns the channel 0 status. A write loads a write-only test and mode register, and that write is accepted only when bit 7 carries a 1. The channel 1 status bits sit in the mask register next to the two mask bits. The same register also shows a strap that tells whether a legacy header is present.

Top module: `dual_irq_status_mask`

## Requirements
- R1: After reset both masks are clear, both bus-master status bits are clear, test mode, legacy mode and the error flag are 0, and a read at offset 3 returns only the strap in bit 4.
- R2: A read at offset 2 returns channel 0 drive status in bit 0 and channel 0 bus-master status in bit 1, with bits 7..2 reading as 0.
- R3: A read at offset 3 returns mask 0 in bit 0, mask 1 in bit 1, channel 1 drive status in bit 2, channel 1 bus-master status in bit 3 and the legacy-header strap in bit 4, with bits 7..5 reading as 0.
- R4: A write at offset 3 loads only the two mask bits from data bits 1..0. Data bits 4..2 have no effect, and those read-back positions keep showing live status and the strap.
- R5: A write at offset 2 with data bit 7 = 1 sets the test-mode output from data bit 0 and the legacy-mode output from data bit 1, starting in the cycle after the write. The status read at offset 2 is unaffected.
- R6: A write at offset 2 with data bit 7 = 0 raises the error output for exactly the one cycle after the write. It leaves test mode and legacy mode unchanged.
- R7: Drive status follows the drive interrupt input after SYNC_STAGES clock edges (2 by default), so a change is not visible after one edge and is visible after two.
- R8: Bus-master status is set by a set pulse and holds until a clear pulse arrives. When set and clear arrive in the same cycle, set wins.
- R9: A channel's host interrupt is active when its drive or bus-master status is set and its mask bit is 0. A masked channel's output is inactive while its status bits still read as set.
- R10: With the polarity input of a channel at 1, the host interrupt of that channel is active-low, so an idle channel drives 1. With the polarity input at 0 the output is active-high.
- R11: Offsets 0 and 1 read as 0, and writes to them change no mask, mode or error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 2 | Byte offset of the I/O access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr, combinational |
| drv_irq | input | 2 | Drive interrupt level, one bit per channel |
| bm_set | input | 2 | Bus-master completion pulse per channel |
| bm_clr | input | 2 | Bus-master status clear pulse per channel |
| pol_low | input | 2 | Output polarity per channel, 1 = active-low |
| legacy_strap | input | 1 | Legacy header present strap |
| host_irq | output | 2 | Host interrupt per channel, after mask and polarity |
| test_mode | output | 1 | Test mode bit from the write-only register |
| legacy_mode | output | 1 | Legacy-compatible mode bit from the write-only register |
| wr_err | output | 1 | One-cycle flag for a status-offset write without bit 7 set |

## Verification
The assertions expect the strap to be held constant while the block is out of reset. They also expect io_wr to be a one-cycle strobe whose address and data are valid in the cycle it is sampled. The bench holds the strap fixed for the whole run. It changes address, data and every interrupt input only on the falling clock edge, so each value is stable at the rising edge that samples it. Set and clear pulses may coincide in the random phase, because R8 defines what happens when they do.

// File: rtl/dism_pkg.sv
package dism_pkg;
   // per-channel status pair
   typedef struct packed {
      logic bm;
      logic drv;
   } ch_sts_t;

   // bit positions of the status offset (channel 0)
   localparam int STS_DRV0_BIT = 0;
   localparam int STS_BM0_BIT  = 1;
   // bit positions of the mask offset
   localparam int MSK_DRV1_BIT  = 2;
   localparam int MSK_BM1_BIT   = 3;
   localparam int MSK_STRAP_BIT = 4;
   // write-only test register
   localparam int TST_MODE_BIT = 0;
   localparam int TST_LEG_BIT  = 1;
   localparam int TST_KEY_BIT  = 7;
endpackage

// File: rtl/dism_sync.sv
module dism_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dism_channel.sv
module dism_channel
   import dism_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    drv_irq,
   input  logic    bm_set,
   input  logic    bm_clr,
   input  logic    mask,
   input  logic    pol_low,
   output ch_sts_t sts,
   output logic    host_irq
);
   logic drv_s;
   logic bm_q;
   logic active;

   dism_sync #(.STAGES(SYNC_STAGES), .W(1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (drv_irq),
      .q    (drv_s)
   );

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bm_q <= 1'b0;
            else if (bm_set) bm_q <= 1'b1;
            else if (bm_clr) bm_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bm_q <= 1'b0;
            else if (bm_clr) bm_q <= 1'b0;
            else if (bm_set) bm_q <= 1'b1;
         end
      end
   endgenerate

   always_comb begin
      sts.drv = drv_s;
      sts.bm  = bm_q;
   end

   assign active   = (drv_s | bm_q) & ~mask;
   assign host_irq = active ^ pol_low;
endmodule

// File: rtl/dism_regs.sv
module dism_regs
   import dism_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 8,
   parameter int NUM_CH     = 2,
   parameter int STS_OFFSET = 2,
   parameter int MSK_OFFSET = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_wr,
   input  logic [DATA_W-1:0]     io_wdata,
   input  ch_sts_t [NUM_CH-1:0]  sts,
   input  logic                  legacy_strap,
   output logic [DATA_W-1:0]     io_rdata,
   output logic [NUM_CH-1:0]     mask,
   output logic                  test_mode,
   output logic                  legacy_mode,
   output logic                  wr_err
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);
   localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFFSET);

   logic hit_sts, hit_msk, key_ok;
   logic unused_wbits;

   assign hit_sts = io_wr && (io_addr == STS_A);
   assign hit_msk = io_wr && (io_addr == MSK_A);
   assign key_ok  = io_wdata[TST_KEY_BIT];
   assign unused_wbits = ^io_wdata;

   // mask register: only the mask field is writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (hit_msk) mask <= io_wdata[NUM_CH-1:0];
   end

   // write-only test/mode register guarded by the key bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_mode   <= 1'b0;
         legacy_mode <= 1'b0;
      end else if (hit_sts && key_ok) begin
         test_mode   <= io_wdata[TST_MODE_BIT];
         legacy_mode <= io_wdata[TST_LEG_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= hit_sts && !key_ok;
   end

   // read multiplexer
   always_comb begin
      io_rdata = '0;
      if (io_addr == STS_A) begin
         io_rdata[STS_DRV0_BIT] = sts[0].drv;
         io_rdata[STS_BM0_BIT]  = sts[0].bm;
      end else if (io_addr == MSK_A) begin
         io_rdata[NUM_CH-1:0]   = mask;
         io_rdata[MSK_DRV1_BIT] = sts[1].drv;
         io_rdata[MSK_BM1_BIT]  = sts[1].bm;
         io_rdata[MSK_STRAP_BIT] = legacy_strap;
      end
   end
endmodule

// File: rtl/dual_irq_status_mask.sv
module dual_irq_status_mask
   import dism_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int STS_OFFSET  = 2,
   parameter int MSK_OFFSET  = 3,
   parameter bit SET_WINS    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic [NUM_CH-1:0] drv_irq,
   input  logic [NUM_CH-1:0] bm_set,
   input  logic [NUM_CH-1:0] bm_clr,
   input  logic [NUM_CH-1:0] pol_low,
   input  logic              legacy_strap,
   output logic [NUM_CH-1:0] host_irq,
   output logic              test_mode,
   output logic              legacy_mode,
   output logic              wr_err
);
   // elaboration-time parameter checks
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8");
      end
      if (NUM_CH != 2) begin : g_bad_ch
         $error("NUM_CH must be 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (STS_OFFSET == MSK_OFFSET) begin : g_bad_off
         $error("status and mask offsets must differ");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   ch_sts_t [NUM_CH-1:0] sts;
   logic    [NUM_CH-1:0] mask_q;
   logic    [NUM_CH-1:0] bm_q;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         dism_channel #(
            .SYNC_STAGES(SYNC_STAGES),
            .SET_WINS   (SET_WINS)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .drv_irq (drv_irq[c]),
            .bm_set  (bm_set[c]),
            .bm_clr  (bm_clr[c]),
            .mask    (mask_q[c]),
            .pol_low (pol_low[c]),
            .sts     (sts[c]),
            .host_irq(host_irq[c])
         );
         assign bm_q[c] = sts[c].bm;
      end
   endgenerate

   dism_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_CH    (NUM_CH),
      .STS_OFFSET(STS_OFFSET),
      .MSK_OFFSET(MSK_OFFSET)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_addr     (io_addr),
      .io_wr       (io_wr),
      .io_wdata    (io_wdata),
      .sts         (sts),
      .legacy_strap(legacy_strap),
      .io_rdata    (io_rdata),
      .mask        (mask_q),
      .test_mode   (test_mode),
      .legacy_mode (legacy_mode),
      .wr_err      (wr_err)
   );
endmodule

// File: rtl/dism_chk.sv
module dism_chk #(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 8,
   parameter int NUM_CH     = 2,
   parameter int STS_OFFSET = 2,
   parameter int MSK_OFFSET = 3,
   parameter bit SET_WINS   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic [NUM_CH-1:0] bm_set,
   input logic [NUM_CH-1:0] bm_clr,
   input logic [NUM_CH-1:0] pol_low,
   input logic              legacy_strap,
   input logic [NUM_CH-1:0] host_irq,
   input logic              test_mode,
   input logic              legacy_mode,
   input logic              wr_err,
   input logic [NUM_CH-1:0] mask_q,
   input logic [NUM_CH-1:0] bm_q
);
   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);
   localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFFSET);

   // R1: everything sticky comes out of reset clear
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_q == '0) && (bm_q == '0) && !test_mode && !wr_err);

   // R2: upper bits of the status offset read as zero
   assert_sts_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == STS_A) |-> (io_rdata[7:2] == '0));

   // R3: strap and reserved bits at the mask offset
   assert_msk_strap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == MSK_A) |-> (io_rdata[4] == legacy_strap) && (io_rdata[7:5] == '0));

   // R6: a keyless write flags an error and leaves the mode bits alone
   assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == STS_A && !io_wdata[7]) |=>
         wr_err && $stable(test_mode) && $stable(legacy_mode));

   assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == STS_A && !io_wdata[7]) |=> !wr_err);

   // R5: a keyed write loads the mode bits
   assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == STS_A && io_wdata[7]) |=>
         (test_mode == $past(io_wdata[0])) && (legacy_mode == $past(io_wdata[1])));

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_p
         // R8: set pulse always leaves the status set (set wins)
         assert_bm_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bm_set[c] && SET_WINS) |=> bm_q[c]);
         // R8: without set or clear the status holds
         assert_bm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!bm_set[c] && !bm_clr[c]) |=> $stable(bm_q[c]));
         // R9 and R10: a masked channel sits at its idle level
         assert_masked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[c] |-> (host_irq[c] == pol_low[c]));
      end
   endgenerate
endmodule

bind dual_irq_status_mask dism_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .NUM_CH    (NUM_CH),
   .STS_OFFSET(STS_OFFSET),
   .MSK_OFFSET(MSK_OFFSET),
   .SET_WINS  (SET_WINS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_addr     (io_addr),
   .io_wr       (io_wr),
   .io_wdata    (io_wdata),
   .io_rdata    (io_rdata),
   .bm_set      (bm_set),
   .bm_clr      (bm_clr),
   .pol_low     (pol_low),
   .legacy_strap(legacy_strap),
   .host_irq    (host_irq),
   .test_mode   (test_mode),
   .legacy_mode (legacy_mode),
   .wr_err      (wr_err),
   .mask_q      (mask_q),
   .bm_q        (bm_q)
);

// File: tb/dual_irq_status_mask_bench.sv
module dual_irq_status_mask_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] io_addr = '0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [1:0] drv_irq = '0, bm_set = '0, bm_clr = '0, pol_low = '0;
   logic       legacy_strap = 1'b1;
   logic [1:0] host_irq;
   logic       test_mode, legacy_mode, wr_err;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dual_irq_status_mask u_dual_irq_status_mask (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .drv_irq(drv_irq),
      .bm_set(bm_set), .bm_clr(bm_clr), .pol_low(pol_low),
      .legacy_strap(legacy_strap), .host_irq(host_irq),
      .test_mode(test_mode), .legacy_mode(legacy_mode), .wr_err(wr_err)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [1:0] m_pipe[$];
   bit [1:0] m_bm, m_mask;
   bit       m_test, m_leg, m_err;

   function automatic bit [1:0] m_drv();
      return m_pipe[0];
   endfunction

   function automatic int exp_rdata(bit [1:0] a);
      bit [1:0] d = m_drv();
      if (a == 2) return {m_bm[0], d[0]};
      if (a == 3) return (int'(legacy_strap) << 4) | (int'(m_bm[1]) << 3) |
                         (int'(d[1]) << 2) | int'(m_mask);
      return 0;
   endfunction

   function automatic int exp_irq();
      bit [1:0] d = m_drv();
      bit [1:0] r;
      for (int c = 0; c < 2; c++)
         r[c] = ((d[c] | m_bm[c]) & ~m_mask[c]) ^ pol_low[c];
      return int'(r);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pipe = '{2'b00, 2'b00};
         m_bm = '0; m_mask = '0; m_test = 0; m_leg = 0; m_err = 0;
      end else begin
         m_pipe.push_back(drv_irq);
         void'(m_pipe.pop_front());
         for (int c = 0; c < 2; c++) begin
            if (bm_set[c])      m_bm[c] = 1'b1;
            else if (bm_clr[c]) m_bm[c] = 1'b0;
         end
         m_err = io_wr && io_addr == 2'd2 && !io_wdata[7];
         if (io_wr && io_addr == 2'd3) m_mask = io_wdata[1:0];
         if (io_wr && io_addr == 2'd2 && io_wdata[7]) begin
            m_test = io_wdata[0];
            m_leg  = io_wdata[1];
         end
      end
   end

   // per-cycle comparison, away from both clock edges
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         case (io_addr)
            2'd2: chk("R2 read status offset", io_rdata, exp_rdata(io_addr));
            2'd3: chk("R3 read mask offset", io_rdata, exp_rdata(io_addr));
            default: chk("R11 read unused offset", io_rdata, 0);
         endcase
         chk("R9 host_irq", host_irq, exp_irq());
         chk("R5 test_mode", test_mode, m_test);
         chk("R5 legacy_mode", legacy_mode, m_leg);
         chk("R6 wr_err", wr_err, m_err);
      end
   end

   // ---------------- directed helpers ----------------
   task automatic wr(bit [1:0] a, bit [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(bit [1:0] a, output int v);
      io_addr = a;
      #1;
      v = io_rdata;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3, v); chk("R1 mask offset after reset", v, 8'h10);
      rd(2, v); chk("R1 status offset after reset", v, 8'h00);
      chk("R1 host_irq after reset", host_irq, 0);
      chk("R1 mode bits after reset", {legacy_mode, test_mode, wr_err}, 0);

      // R7 drive status latency
      drv_irq = 2'b01;
      @(negedge clk); rd(2, v); chk("R7 after one edge", v, 0);
      @(negedge clk); rd(2, v); chk("R7 after two edges", v, 1);
      chk("R9 unmasked drive raises host_irq", host_irq, 2'b01);

      // R9 masking
      wr(3, 8'h01); #1;
      chk("R9 masked channel idle", host_irq, 2'b00);
      rd(2, v); chk("R9 status still set while masked", v, 1);

      // R4 only mask bits writable
      wr(3, 8'h1E); rd(3, v);
      chk("R4 write ignores bits 4..2", v, 8'h12);
      chk("R4 mask switched channels", host_irq, 2'b01);
      drv_irq = 2'b00;
      wr(3, 8'h00);

      // R8 sticky bus-master status
      bm_set = 2'b10; @(negedge clk); bm_set = 2'b00;
      rd(3, v); chk("R8 set pulse", v, 8'h18);
      repeat (3) @(negedge clk);
      rd(3, v); chk("R8 status holds", v, 8'h18);
      chk("R8 host_irq from bus master", host_irq, 2'b10);
      bm_clr = 2'b10; @(negedge clk); bm_clr = 2'b00;
      rd(3, v); chk("R8 clear pulse", v, 8'h10);
      bm_set = 2'b01; bm_clr = 2'b01; @(negedge clk); bm_set = 0; bm_clr = 0;
      rd(2, v); chk("R8 set wins over clear", v, 8'h02);
      bm_clr = 2'b01; @(negedge clk); bm_clr = 0;
      rd(2, v); chk("R8 cleared channel 0", v, 0);

      // R10 polarity
      pol_low = 2'b10; #1;
      chk("R10 idle active-low channel", host_irq, 2'b10);
      bm_set = 2'b10; @(negedge clk); bm_set = 0; #1;
      chk("R10 asserted active-low channel", host_irq, 2'b00);
      bm_clr = 2'b10; @(negedge clk); bm_clr = 0; pol_low = 2'b00;

      // R5 keyed test register write
      wr(2, 8'h83); #1;
      chk("R5 test_mode loaded", test_mode, 1);
      chk("R5 legacy_mode loaded", legacy_mode, 1);
      rd(2, v); chk("R5 status read unaffected", v, 0);

      // R6 keyless write
      wr(2, 8'h00); #1;
      chk("R6 error raised", wr_err, 1);
      chk("R6 modes kept", {legacy_mode, test_mode}, 2'b11);
      @(negedge clk); #1;
      chk("R6 error lasts one cycle", wr_err, 0);

      // R11 unused offsets
      wr(0, 8'hFF); wr(1, 8'hFF);
      rd(0, v); chk("R11 offset 0 reads zero", v, 0);
      rd(1, v); chk("R11 offset 1 reads zero", v, 0);
      rd(3, v); chk("R11 mask untouched", v, 8'h10);
      chk("R11 modes untouched", {legacy_mode, test_mode, wr_err}, 3'b110);

      // random phase, checked by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         io_addr  = 2'($urandom_range(0, 3));
         io_wdata = 8'($urandom);
         io_wr    = ($urandom_range(0, 9) < 3);
         drv_irq  = 2'($urandom);
         bm_set   = ($urandom_range(0, 9) < 2) ? 2'($urandom) : 2'b00;
         bm_clr   = ($urandom_range(0, 9) < 2) ? 2'($urandom) : 2'b00;
         if ((i % 500) == 0) pol_low = 2'($urandom);
      end
      @(negedge clk); io_wr = 1'b0;
      repeat (4) @(negedge clk);
      #3;
      finish_run();
   end
endmodule